// File: doc/BRIEF.md
# Microprogrammed Datapath Controller

This block is the control unit of a small register-to-register processor datapath. It holds the program counter, an instruction register and a two-bit flags register (zero and negative), and it steps through a microprogram held in a ROM. A microprogram counter addresses the ROM. Each cycle the ROM word is turned into one control word for the datapath: register-bank drive and load enables with their register selects, the ALU P/K/R function codes and carry-in, result-latch load and drive, and MAR/MDR loads. The ALU, the register bank and memory are outside the block.

The microprogram counter steps forward by default. At the end of fetch it jumps to a dispatch address chosen from the opcode of the word being fetched. A conditional microbranch tests a latched flag and, when the flag is set, jumps to a target held in the ROM word. The last microstep of every instruction sends the counter back to fetch. The flag inputs from the datapath reach the sequencer only through the flags register, and that register loads only in microsteps that ask for it.

Instruction fetch and the store write are valid/ready handshakes. The controller raises `imem_valid` with `imem_addr` equal to the PC. It holds both until `imem_ready` is high at a rising edge, and `imem_data` is taken in that same cycle. `store_valid` is held until `store_ready`. While a handshake waits, the microprogram counter, PC and IR do not move and no other control output changes. Memory may hold off either handshake for any number of cycles.

Top module: `ctl_microseq`

## Requirements
- R1: While reset is held and in the first cycle after it, `imem_valid`=1 and `imem_addr`=0, both flags are 0, and every other enable output is 0.
- R2: While `imem_valid`=1 and `imem_ready`=0, `imem_valid` and `imem_addr` hold and no other enable is active. In the cycle where both are 1, the IR takes `imem_data` and the PC advances by one. Instruction word fields: opcode [15:12], first register rs1 [11:8], second register rs2 [7:4], branch offset [7:0] as a signed byte.
- R3: Opcodes 0 to 4 (ADD, SUB, AND, OR, XOR) take two cycles after the fetch handshake. In the first, `bus_a_drive`=1 with `bus_a_sel`=rs1, `bus_b_drive`=1 with `bus_b_sel`=rs2, and `res_latch_load`=1. In the second, `res_latch_drive`=1 and `rf_load`=1 with `rf_load_sel`=rs1, while `bus_a_drive`=0.
- R4: ALU codes {p,k,r,cin} during the compute cycle are: ADD {0110,10,0110,0}, SUB and CMP {1001,10,0110,1}, AND {1000,00,1000,0}, OR {1110,00,1110,0}, XOR {0110,00,0110,0}. In every other cycle all four are 0.
- R5: `flag_z` and `flag_n` take `zero_in` and `neg_in` only at the edge that ends a flag-load microstep: the writeback cycle of opcodes 0 to 4, and the second cycle of CMP. At all other times they hold.
- R6: Store (opcode 5) drives rs1 on bus A with `mdr_load`=1 and rs2 on bus B with `mar_load`=1 in one cycle. In the next cycle it raises `store_valid`, which holds until `store_ready`.
- R7: Branch-if-zero (opcode 6) and branch-if-negative (opcode 7) use two idle cycles after fetch. If the latched flag is 1, the next fetch address is the incremented PC plus the sign-extended offset. Otherwise it is the incremented PC.
- R8: CMP (opcode 8) does the compute cycle of R3 with the SUB codes and then a flag-load cycle. It never asserts `rf_load` or `res_latch_drive`.
- R9: Opcodes 9 to 15 spend one idle cycle and then fetch the next sequential word.
- R10: Every instruction returns to fetch: `imem_valid` comes back with the expected address, and it is never high in the same cycle as `store_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_valid | output | 1 | Instruction fetch request |
| imem_ready | input | 1 | Memory accepts fetch, data valid |
| imem_addr | output | 8 | Fetch address (PC) |
| imem_data | input | 16 | Fetched instruction word |
| store_valid | output | 1 | Memory write request (MAR/MDR) |
| store_ready | input | 1 | Memory accepts the write |
| bus_a_sel | output | 4 | Register driving bus A |
| bus_a_drive | output | 1 | Register bank drives bus A |
| bus_b_sel | output | 4 | Register driving bus B |
| bus_b_drive | output | 1 | Register bank drives bus B |
| rf_load | output | 1 | Register bank loads from bus A |
| rf_load_sel | output | 4 | Register being loaded |
| alu_p | output | 4 | ALU P code |
| alu_k | output | 2 | ALU K code |
| alu_r | output | 4 | ALU R code |
| alu_cin | output | 1 | ALU carry-in |
| res_latch_load | output | 1 | ALU output latch loads |
| res_latch_drive | output | 1 | ALU output latch drives bus A |
| mar_load | output | 1 | MAR loads from bus B |
| mdr_load | output | 1 | MDR loads from bus A |
| zero_in | input | 1 | Zero indication from datapath |
| neg_in | input | 1 | Negative indication from datapath |
| flag_z | output | 1 | Latched zero flag |
| flag_n | output | 1 | Latched negative flag |

## Verification
The hardest case to reach is a taken conditional microbranch. The flag it tests can be set only by an earlier instruction's flag-load step, and the datapath indications must have the wanted values in exactly that one cycle. The bench therefore runs a CMP with `zero_in`/`neg_in` at the wanted values only in its flag-load cycle, and at the opposite values in every other cycle. The branch that follows then shows both that the flag was latched and that the jump landed at the right address. Positive and negative offsets are both covered, along with the not-taken path.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OPW = 4;
  localparam int UAW = 5;

  typedef enum logic [2:0] {SQ_NEXT, SQ_DISP, SQ_BZ, SQ_BN, SQ_FETCH} seq_e;

  localparam logic [UAW-1:0] UA_FETCH  = 5'd0;
  localparam logic [UAW-1:0] UA_ALU    = 5'd1;
  localparam logic [UAW-1:0] UA_ALU_WB = 5'd2;
  localparam logic [UAW-1:0] UA_ST     = 5'd3;
  localparam logic [UAW-1:0] UA_ST_WR  = 5'd4;
  localparam logic [UAW-1:0] UA_BZ     = 5'd5;
  localparam logic [UAW-1:0] UA_BZ_NT  = 5'd6;
  localparam logic [UAW-1:0] UA_TAKE   = 5'd7;
  localparam logic [UAW-1:0] UA_BN     = 5'd8;
  localparam logic [UAW-1:0] UA_BN_NT  = 5'd9;
  localparam logic [UAW-1:0] UA_CMP    = 5'd10;
  localparam logic [UAW-1:0] UA_CMP_FL = 5'd11;
  localparam logic [UAW-1:0] UA_BAD    = 5'd12;

  localparam logic [OPW-1:0] OP_ADD = 4'd0;
  localparam logic [OPW-1:0] OP_SUB = 4'd1;
  localparam logic [OPW-1:0] OP_AND = 4'd2;
  localparam logic [OPW-1:0] OP_OR  = 4'd3;
  localparam logic [OPW-1:0] OP_XOR = 4'd4;
  localparam logic [OPW-1:0] OP_ST  = 4'd5;
  localparam logic [OPW-1:0] OP_BZ  = 4'd6;
  localparam logic [OPW-1:0] OP_BN  = 4'd7;
  localparam logic [OPW-1:0] OP_CMP = 4'd8;

  typedef struct packed {
    logic           fetch;
    logic           a_drv;
    logic           b_drv;
    logic           out_ld;
    logic           out_drv;
    logic           rf_ld;
    logic           mar_ld;
    logic           mdr_ld;
    logic           st;
    logic           flg_ld;
    logic           pc_br;
    logic           alu_en;
    seq_e           seq;
    logic [UAW-1:0] tgt;
  } uword_t;

  typedef struct packed {
    logic [3:0] p;
    logic [1:0] k;
    logic [3:0] r;
    logic       cin;
  } alu_code_t;

  function automatic alu_code_t alu_code(input logic [OPW-1:0] op);
    alu_code_t c;
    c = '0;
    case (op)
      OP_ADD:         c = '{p: 4'b0110, k: 2'b10, r: 4'b0110, cin: 1'b0};
      OP_SUB, OP_CMP: c = '{p: 4'b1001, k: 2'b10, r: 4'b0110, cin: 1'b1};
      OP_AND:         c = '{p: 4'b1000, k: 2'b00, r: 4'b1000, cin: 1'b0};
      OP_OR:          c = '{p: 4'b1110, k: 2'b00, r: 4'b1110, cin: 1'b0};
      OP_XOR:         c = '{p: 4'b0110, k: 2'b00, r: 4'b0110, cin: 1'b0};
      default:        c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [UAW-1:0] dispatch(input logic [OPW-1:0] op);
    logic [UAW-1:0] a;
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: a = UA_ALU;
      OP_ST:   a = UA_ST;
      OP_BZ:   a = UA_BZ;
      OP_BN:   a = UA_BN;
      OP_CMP:  a = UA_CMP;
      default: a = UA_BAD;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/ctl_urom.sv
module ctl_urom
  import ctl_pkg::*;
(
  input  logic [UAW-1:0] addr,
  output uword_t         word
);
  // microprogram contents, computed per address
  function automatic uword_t rom_word(input logic [UAW-1:0] a);
    uword_t w;
    w     = '0;
    w.seq = SQ_FETCH;
    case (a)
      UA_FETCH: begin
        w.fetch = 1'b1;
        w.seq   = SQ_DISP;
      end
      UA_ALU, UA_CMP: begin
        w.a_drv  = 1'b1;
        w.b_drv  = 1'b1;
        w.out_ld = 1'b1;
        w.alu_en = 1'b1;
        w.seq    = SQ_NEXT;
      end
      UA_ALU_WB: begin
        w.out_drv = 1'b1;
        w.rf_ld   = 1'b1;
        w.flg_ld  = 1'b1;
      end
      UA_ST: begin
        w.a_drv  = 1'b1;
        w.b_drv  = 1'b1;
        w.mdr_ld = 1'b1;
        w.mar_ld = 1'b1;
        w.seq    = SQ_NEXT;
      end
      UA_ST_WR: w.st = 1'b1;
      UA_BZ: begin
        w.seq = SQ_BZ;
        w.tgt = UA_TAKE;
      end
      UA_BN: begin
        w.seq = SQ_BN;
        w.tgt = UA_TAKE;
      end
      UA_TAKE:   w.pc_br  = 1'b1;
      UA_CMP_FL: w.flg_ld = 1'b1;
      default:   w.seq    = SQ_FETCH;
    endcase
    return w;
  endfunction

  always_comb word = rom_word(addr);
endmodule

// File: rtl/ctl_useq.sv
module ctl_useq
  import ctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stall,
  input  seq_e           seq,
  input  logic [UAW-1:0] tgt,
  input  logic [OPW-1:0] fetch_op,
  input  logic           flag_z,
  input  logic           flag_n,
  output logic [UAW-1:0] upc
);
  logic [UAW-1:0] nxt;
  logic [UAW-1:0] inc;

  assign inc = upc + UAW'(1);

  always_comb begin
    if (stall) nxt = upc;
    else begin
      case (seq)
        SQ_NEXT:  nxt = inc;
        SQ_DISP:  nxt = dispatch(fetch_op);
        SQ_BZ:    nxt = flag_z ? tgt : inc;
        SQ_BN:    nxt = flag_n ? tgt : inc;
        SQ_FETCH: nxt = UA_FETCH;
        default:  nxt = UA_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upc <= UA_FETCH;
    else        upc <= nxt;
  end
endmodule

// File: rtl/ctl_arch_regs.sv
module ctl_arch_regs
  import ctl_pkg::*;
#(
  parameter int IW   = 16,
  parameter int AW   = 8,
  parameter int RAW  = 4,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_ld,
  input  logic [IW-1:0]   ir_d,
  input  logic            pc_br,
  input  logic            flg_ld,
  input  logic            zero_in,
  input  logic            neg_in,
  output logic [AW-1:0]   pc,
  output logic [OPW-1:0]  op,
  output logic [RAW-1:0]  rs1,
  output logic [RAW-1:0]  rs2,
  output logic            flag_z,
  output logic            flag_n
);
  localparam int RS1_LSB = IW - OPW - RAW;
  localparam int RS2_LSB = RS1_LSB - RAW;

  logic [IW-1:0] ir;
  logic [AW-1:0] offs;

  assign offs = AW'($signed(ir[OFFW-1:0]));
  assign op   = ir[IW-1 -: OPW];
  assign rs1  = ir[RS1_LSB +: RAW];
  assign rs2  = ir[RS2_LSB +: RAW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir     <= '0;
      pc     <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      if (ir_ld) begin
        ir <= ir_d;
        pc <= pc + AW'(1);
      end else if (pc_br) begin
        pc <= pc + offs;
      end
      if (flg_ld) begin
        flag_z <= zero_in;
        flag_n <= neg_in;
      end
    end
  end
endmodule

// File: rtl/ctl_cw_drive.sv
module ctl_cw_drive
  import ctl_pkg::*;
#(
  parameter int RAW = 4
) (
  input  logic           alu_en,
  input  logic [OPW-1:0] op,
  input  logic [RAW-1:0] rs1,
  input  logic [RAW-1:0] rs2,
  output logic [RAW-1:0] bus_a_sel,
  output logic [RAW-1:0] bus_b_sel,
  output logic [RAW-1:0] rf_load_sel,
  output logic [3:0]     alu_p,
  output logic [1:0]     alu_k,
  output logic [3:0]     alu_r,
  output logic           alu_cin
);
  alu_code_t code;

  always_comb begin
    code = alu_en ? alu_code(op) : '0;
  end

  assign alu_p       = code.p;
  assign alu_k       = code.k;
  assign alu_r       = code.r;
  assign alu_cin     = code.cin;
  assign bus_a_sel   = rs1;
  assign bus_b_sel   = rs2;
  assign rf_load_sel = rs1;
endmodule

// File: rtl/ctl_microseq.sv
module ctl_microseq
  import ctl_pkg::*;
#(
  parameter int IW   = 16,
  parameter int AW   = 8,
  parameter int RAW  = 4,
  parameter int OFFW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           imem_valid,
  input  logic           imem_ready,
  output logic [AW-1:0]  imem_addr,
  input  logic [IW-1:0]  imem_data,
  output logic           store_valid,
  input  logic           store_ready,
  output logic [RAW-1:0] bus_a_sel,
  output logic           bus_a_drive,
  output logic [RAW-1:0] bus_b_sel,
  output logic           bus_b_drive,
  output logic           rf_load,
  output logic [RAW-1:0] rf_load_sel,
  output logic [3:0]     alu_p,
  output logic [1:0]     alu_k,
  output logic [3:0]     alu_r,
  output logic           alu_cin,
  output logic           res_latch_load,
  output logic           res_latch_drive,
  output logic           mar_load,
  output logic           mdr_load,
  input  logic           zero_in,
  input  logic           neg_in,
  output logic           flag_z,
  output logic           flag_n
);
  logic [UAW-1:0] upc;
  uword_t         uw;
  logic           fetch_fire;
  logic           stall;
  logic [OPW-1:0] op;
  logic [RAW-1:0] rs1;
  logic [RAW-1:0] rs2;

  assign fetch_fire = uw.fetch & imem_ready;
  assign stall      = (uw.fetch & ~imem_ready) | (uw.st & ~store_ready);

  ctl_urom u_rom (.addr(upc), .word(uw));

  ctl_useq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .seq      (uw.seq),
    .tgt      (uw.tgt),
    .fetch_op (imem_data[IW-1 -: OPW]),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .upc      (upc)
  );

  ctl_arch_regs #(.IW(IW), .AW(AW), .RAW(RAW), .OFFW(OFFW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir_ld   (fetch_fire),
    .ir_d    (imem_data),
    .pc_br   (uw.pc_br),
    .flg_ld  (uw.flg_ld),
    .zero_in (zero_in),
    .neg_in  (neg_in),
    .pc      (imem_addr),
    .op      (op),
    .rs1     (rs1),
    .rs2     (rs2),
    .flag_z  (flag_z),
    .flag_n  (flag_n)
  );

  ctl_cw_drive #(.RAW(RAW)) u_cw (
    .alu_en      (uw.alu_en),
    .op          (op),
    .rs1         (rs1),
    .rs2         (rs2),
    .bus_a_sel   (bus_a_sel),
    .bus_b_sel   (bus_b_sel),
    .rf_load_sel (rf_load_sel),
    .alu_p       (alu_p),
    .alu_k       (alu_k),
    .alu_r       (alu_r),
    .alu_cin     (alu_cin)
  );

  assign imem_valid      = uw.fetch;
  assign store_valid     = uw.st;
  assign bus_a_drive     = uw.a_drv;
  assign bus_b_drive     = uw.b_drv;
  assign rf_load         = uw.rf_ld;
  assign res_latch_load  = uw.out_ld;
  assign res_latch_drive = uw.out_drv;
  assign mar_load        = uw.mar_ld;
  assign mdr_load        = uw.mdr_ld;
endmodule

// File: rtl/ctl_microseq_chk.sv
module ctl_microseq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          imem_valid,
  input logic          imem_ready,
  input logic [AW-1:0] imem_addr,
  input logic          store_valid,
  input logic          store_ready,
  input logic          bus_a_drive,
  input logic          rf_load,
  input logic          res_latch_load,
  input logic          res_latch_drive,
  input logic          flag_z,
  input logic          flag_n
);
  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (imem_valid && imem_addr == '0 && !flag_z && !flag_n)); // R1

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_valid && !imem_ready) |=> (imem_valid && $stable(imem_addr))); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_valid && imem_ready) |=> (imem_addr == $past(imem_addr) + AW'(1))); // R2

  AST_WB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_load |-> (res_latch_drive && !bus_a_drive)); // R3

  AST_FLAGS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_valid || store_valid || res_latch_load) |=> $stable({flag_z, flag_n})); // R5

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && !store_ready) |=> store_valid); // R6

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_valid && store_valid)); // R10
endmodule

bind ctl_microseq ctl_microseq_chk #(.AW(AW)) u_chk (.*);

// File: tb/ctl_microseq_test.sv
module ctl_microseq_test;
  localparam int IW = 16;
  localparam int AW = 8;
  localparam int RAW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic imem_ready = 1'b0;
  logic store_ready = 1'b0;
  logic zero_in = 1'b0;
  logic neg_in = 1'b0;
  logic imem_valid, store_valid, bus_a_drive, bus_b_drive, rf_load;
  logic res_latch_load, res_latch_drive, mar_load, mdr_load, alu_cin;
  logic flag_z, flag_n;
  logic [AW-1:0] imem_addr;
  logic [IW-1:0] imem_data;
  logic [RAW-1:0] bus_a_sel, bus_b_sel, rf_load_sel;
  logic [3:0] alu_p, alu_r;
  logic [1:0] alu_k;

  logic [IW-1:0] mem [0:(1<<AW)-1];
  assign imem_data = mem[imem_addr];

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] exp_pc = '0;
  logic exp_z = 1'b0;
  logic exp_n = 1'b0;

  always #2 clk = ~clk;

  ctl_microseq uut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] enables();
    return {bus_a_drive, bus_b_drive, rf_load, res_latch_load,
            res_latch_drive, mar_load, mdr_load, store_valid};
  endfunction

  function automatic logic [10:0] exp_codes(input logic [3:0] op);
    case (op)
      4'd0:       return {4'b0110, 2'b10, 4'b0110, 1'b0};
      4'd1, 4'd8: return {4'b1001, 2'b10, 4'b0110, 1'b1};
      4'd2:       return {4'b1000, 2'b00, 4'b1000, 1'b0};
      4'd3:       return {4'b1110, 2'b00, 4'b1110, 1'b0};
      4'd4:       return {4'b0110, 2'b00, 4'b0110, 1'b0};
      default:    return '0;
    endcase
  endfunction

  task automatic do_fetch(input logic [IW-1:0] instr, input int waits);
    mem[exp_pc] = instr;
    chk("R10 fetch valid", imem_valid, 1);
    chk("R10 fetch addr", imem_addr, exp_pc);
    for (int i = 0; i < waits; i++) begin
      imem_ready = 1'b0;
      tick();
      chk("R2 valid held", imem_valid, 1);
      chk("R2 addr held", imem_addr, exp_pc);
      chk("R2 no enables in wait", enables(), 0);
    end
    imem_ready = 1'b1;
    tick();
    imem_ready = 1'b0;
    exp_pc = exp_pc + 1'b1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 valid in reset", imem_valid, 1);
    chk("R1 addr in reset", imem_addr, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 valid", imem_valid, 1);
    chk("R1 addr", imem_addr, 0);
    chk("R1 flags", {flag_z, flag_n}, 0);
    chk("R1 enables", enables(), 0);
    chk("R1 alu codes", {alu_p, alu_k, alu_r, alu_cin}, 0);
  endtask

  task automatic test_alu(input logic [3:0] op, input logic [3:0] ra, input logic [3:0] rb,
                          input logic z, input logic n, input int waits);
    do_fetch({op, ra, rb, 4'h0}, waits);
    chk("R3 compute drives", {bus_a_drive, bus_b_drive, res_latch_load, rf_load}, 4'b1110);
    chk("R3 a sel", bus_a_sel, ra);
    chk("R3 b sel", bus_b_sel, rb);
    chk("R4 alu codes", {alu_p, alu_k, alu_r, alu_cin}, exp_codes(op));
    zero_in = ~z;
    neg_in  = ~n;
    tick();
    chk("R5 flags held in compute", {flag_z, flag_n}, {exp_z, exp_n});
    chk("R3 wb enables", {res_latch_drive, rf_load, bus_a_drive}, 3'b110);
    chk("R3 wb sel", rf_load_sel, ra);
    chk("R4 codes idle in wb", {alu_p, alu_k, alu_r, alu_cin}, 0);
    zero_in = z;
    neg_in  = n;
    tick();
    exp_z = z;
    exp_n = n;
    chk("R5 flags loaded", {flag_z, flag_n}, {exp_z, exp_n});
    zero_in = ~z;
    neg_in  = ~n;
  endtask

  task automatic test_cmp(input logic z, input logic n);
    do_fetch({4'd8, 4'h3, 4'h4, 4'h0}, 0);
    chk("R8 compute drives", {bus_a_drive, bus_b_drive, res_latch_load}, 3'b111);
    chk("R8 sub codes", {alu_p, alu_k, alu_r, alu_cin}, exp_codes(4'd1));
    zero_in = ~z;
    neg_in  = ~n;
    tick();
    chk("R8 no writeback", {rf_load, res_latch_drive}, 0);
    zero_in = z;
    neg_in  = n;
    tick();
    exp_z = z;
    exp_n = n;
    chk("R8 flags loaded", {flag_z, flag_n}, {exp_z, exp_n});
    zero_in = ~z;
    neg_in  = ~n;
  endtask

  task automatic test_branch(input logic [3:0] op, input logic [7:0] off, input logic taken);
    do_fetch({op, 4'h0, off}, 0);
    chk("R7 test step idle", {enables(), imem_valid}, 0);
    tick();
    chk("R7 second step idle", {enables(), imem_valid}, 0);
    tick();
    if (taken) exp_pc = exp_pc + off;
    chk("R7 next fetch addr", imem_addr, exp_pc);
    chk("R7 fetch back", imem_valid, 1);
    chk("R5 flags kept by branch", {flag_z, flag_n}, {exp_z, exp_n});
  endtask

  task automatic test_store(input logic [3:0] ra, input logic [3:0] rb, input int waits);
    do_fetch({4'd5, ra, rb, 4'h0}, 0);
    chk("R6 bus and mdr/mar", {bus_a_drive, bus_b_drive, mdr_load, mar_load, rf_load}, 5'b11110);
    chk("R6 sels", {bus_a_sel, bus_b_sel}, {ra, rb});
    tick();
    chk("R6 store valid", store_valid, 1);
    chk("R6 only store", enables(), 8'h01);
    for (int i = 0; i < waits; i++) begin
      store_ready = 1'b0;
      tick();
      chk("R6 store held", store_valid, 1);
      chk("R10 no fetch during store", imem_valid, 0);
    end
    store_ready = 1'b1;
    tick();
    store_ready = 1'b0;
    chk("R10 fetch after store", imem_valid, 1);
    chk("R10 addr after store", imem_addr, exp_pc);
  endtask

  task automatic test_bad(input logic [3:0] op);
    do_fetch({op, 12'hABC}, 1);
    chk("R9 idle step", {enables(), imem_valid}, 0);
    tick();
    chk("R9 fetch next", imem_valid, 1);
    chk("R9 sequential addr", imem_addr, exp_pc);
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    test_reset();
    test_alu(4'd0, 4'h1, 4'h2, 1'b1, 1'b0, 2);
    test_alu(4'd1, 4'h5, 4'h6, 1'b0, 1'b1, 0);
    test_alu(4'd2, 4'h7, 4'h8, 1'b0, 1'b0, 1);
    test_alu(4'd3, 4'h9, 4'hA, 1'b1, 1'b0, 0);
    test_alu(4'd4, 4'hB, 4'hC, 1'b0, 1'b0, 3);
    test_cmp(1'b0, 1'b1);
    test_branch(4'd7, 8'h05, 1'b1);
    test_branch(4'd6, 8'h10, 1'b0);
    test_cmp(1'b1, 1'b0);
    test_branch(4'd6, 8'hFD, 1'b1);
    test_branch(4'd7, 8'h20, 1'b0);
    test_store(4'h2, 4'hD, 2);
    test_store(4'hE, 4'h1, 0);
    test_bad(4'hB);
    test_bad(4'hF);
    test_alu(4'd0, 4'hF, 4'h0, 1'b0, 1'b0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule